// File: doc/BRIEF.md
# Cursor Register Bank

This block stores the programming of a display hardware cursor and hands a coherent set of parameters to the cursor fetch and blend logic. Software reaches it through a small word-addressed write port and a combinational read port. Every write lands in a shadow copy. A commit state machine copies the whole shadow set into the active set on a frame-boundary strobe, so the downstream pipeline never sees a half-finished update. The parameters are enable, X/Y position, hotspot offsets, size, blend mode, 2x magnification, inverse-transparent clamping, two colours and a 40-bit surface base address.

Software sets an update-lock bit, programs any number of registers, and then clears the lock. The staged values move into the active set on the first strobe seen with the lock clear. The surface address is assembled from two writes. The upper byte goes into a staging register first. The write to the lower word then completes the address.

The commit state machine has three states. CS_CLEAN means the shadow equals the active set. CS_HELD means changes are pending while the lock is set. CS_WAIT means changes are pending and the lock is clear. Its transitions are:
- CLEAN→HELD: a shadow write while locked.
- CLEAN→WAIT: a shadow write while unlocked.
- HELD→WAIT: the lock clears with no strobe.
- WAIT→HELD: the lock is set.
- HELD/WAIT→CLEAN: a commit with no write in the same cycle.
- HELD/WAIT→WAIT: a commit that coincides with a new shadow write.

Top module: `cursor_regbank`

## Requirements
- R1: After reset, all active outputs are zero (mode 0, one-pixel size, address 0). The status register reads 0.
- R2: While the lock bit (register 8, bit 0) is 1, the active outputs do not change, even when strobes arrive.
- R3: Active outputs change only on a cycle with frame_strobe high and the lock clear. If the lock clears between strobes, the new values appear only at the next strobe.
- R4: Register 8, bit 1 reads 1 after any write to registers 0–5 or 7. It reads 0 after a commit that has no write in the same cycle.
- R5: Reading any register returns its shadow (staged) value, not the active value.
- R6: Mode codes are 0 monochrome, 1 colour with 1-bit AND mask, 2 premultiplied alpha, 3 straight alpha. In mode 0 the colour outputs are forced to black (colour 1) and white 24'hFFFFFF (colour 2). In the other modes the programmed colours pass through. The colour registers are 4 and 5, with blue in [7:0], green in [15:8] and red in [23:16].
- R7: The size register (3) holds width−1 in [7:0] and height−1 in [15:8]. These values appear unchanged on cur_width_m1 and cur_height_m1, so 0 means one pixel.
- R8: A write to the high address register (6, data [7:0]) only stages bits 39:32. Register 6 reads back the staged byte. The base address changes only after a later write to register 7 followed by a commit.
- R9: Register 7 holds address bits 31:12. Write data bits [11:0] are ignored and read back as zero, so the address is always 4 KiB aligned.
- R10: The control register (0) has enable in [0], mode in [2:1], magnify in [3] and clamp in [4]. The position register (1) has X in [12:0] and Y in [28:16]. The hotspot register (2) has X in [5:0] and Y in [13:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register index for the read |
| rd_data | output | 32 | Shadow readback (combinational) |
| frame_strobe | input | 1 | Frame-boundary pulse |
| cur_enable | output | 1 | Active cursor enable |
| cur_mode | output | 2 | Active blend mode |
| cur_mag2x | output | 1 | Active 2x magnification |
| cur_clamp | output | 1 | Active inverse-transparent clamp |
| cur_pos_x | output | 13 | Active X position |
| cur_pos_y | output | 13 | Active Y position |
| cur_hot_x | output | 6 | Active hotspot X |
| cur_hot_y | output | 6 | Active hotspot Y |
| cur_width_m1 | output | 8 | Active width minus one |
| cur_height_m1 | output | 8 | Active height minus one |
| cur_color1 | output | 24 | Effective colour 1 |
| cur_color2 | output | 24 | Effective colour 2 |
| cur_base_addr | output | 40 | Active surface byte address |

## Verification
The bench covers three write patterns: a plain unlocked write followed by a strobe, a locked burst with strobes arriving during the lock, and a lock released between strobes. The first shows that the commit waits for a strobe. The second shows that the lock blocks the commit. The third separates "commit on the first strobe after release" from "commit at release". The address tests write the high byte alone and then the high/low pair, with the low bits set to all ones, which distinguishes staging from completion and shows the page bits being dropped. The mode tests switch between mode 2 and mode 0 with the same colour registers, which shows whether the monochrome override is applied.

// File: rtl/cur_regs_pkg.sv
`timescale 1ns/1ps
package cur_regs_pkg;
    parameter int COORD_W   = 13;
    parameter int HOT_W     = 6;
    parameter int SIZE_W    = 8;
    parameter int ADDR_W    = 40;
    parameter int PAGE_BITS = 12;
    parameter int DATA_W    = 32;
    parameter int SEL_W     = 4;
    parameter int COLOR_W   = 24;
    localparam int HI_W     = ADDR_W - DATA_W;
    localparam int LO_W     = DATA_W - PAGE_BITS;
    localparam int Y_LSB    = 16;
    localparam int HOTY_LSB = 8;
    localparam int H_LSB    = 8;

    typedef enum logic [1:0] {
        MODE_MONO     = 2'd0,
        MODE_AND_MASK = 2'd1,
        MODE_PREMUL   = 2'd2,
        MODE_STRAIGHT = 2'd3
    } cur_mode_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 4'd0, SEL_POS  = 4'd1, SEL_HOT  = 4'd2,
        SEL_SIZE = 4'd3, SEL_COL1 = 4'd4, SEL_COL2 = 4'd5,
        SEL_AHI  = 4'd6, SEL_ALO  = 4'd7, SEL_LOCK = 4'd8
    } reg_sel_e;

    typedef enum logic [1:0] {
        CS_CLEAN = 2'd0,
        CS_HELD  = 2'd1,
        CS_WAIT  = 2'd2
    } commit_state_e;

    typedef struct packed {
        logic               enable;
        cur_mode_e          mode;
        logic               mag2x;
        logic               clamp;
        logic [COORD_W-1:0] pos_x;
        logic [COORD_W-1:0] pos_y;
        logic [HOT_W-1:0]   hot_x;
        logic [HOT_W-1:0]   hot_y;
        logic [SIZE_W-1:0]  w_m1;
        logic [SIZE_W-1:0]  h_m1;
        logic [COLOR_W-1:0] col1;
        logic [COLOR_W-1:0] col2;
        logic [HI_W-1:0]    addr_hi;
        logic [LO_W-1:0]    addr_lo;
    } cursor_cfg_t;
endpackage

// File: rtl/cur_shadow_file.sv
`timescale 1ns/1ps
module cur_shadow_file
    import cur_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_addr,
    input  logic              pending,
    output logic [DATA_W-1:0] rd_data,
    output cursor_cfg_t       shadow,
    output logic              lock_q,
    output logic              dirty_wr
);
    logic [HI_W-1:0] hi_stage;

    always_comb begin
        dirty_wr = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_CTRL, SEL_POS, SEL_HOT, SEL_SIZE,
                SEL_COL1, SEL_COL2, SEL_ALO: dirty_wr = 1'b1;
                default:                     dirty_wr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow   <= '0;
            hi_stage <= '0;
            lock_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_CTRL: begin
                    shadow.enable <= wr_data[0];
                    shadow.mode   <= cur_mode_e'(wr_data[2:1]);
                    shadow.mag2x  <= wr_data[3];
                    shadow.clamp  <= wr_data[4];
                end
                SEL_POS: begin
                    shadow.pos_x <= wr_data[COORD_W-1:0];
                    shadow.pos_y <= wr_data[Y_LSB +: COORD_W];
                end
                SEL_HOT: begin
                    shadow.hot_x <= wr_data[HOT_W-1:0];
                    shadow.hot_y <= wr_data[HOTY_LSB +: HOT_W];
                end
                SEL_SIZE: begin
                    shadow.w_m1 <= wr_data[SIZE_W-1:0];
                    shadow.h_m1 <= wr_data[H_LSB +: SIZE_W];
                end
                SEL_COL1: shadow.col1 <= wr_data[COLOR_W-1:0];
                SEL_COL2: shadow.col2 <= wr_data[COLOR_W-1:0];
                SEL_AHI:  hi_stage    <= wr_data[HI_W-1:0];
                SEL_ALO: begin
                    shadow.addr_hi <= hi_stage;
                    shadow.addr_lo <= wr_data[DATA_W-1:PAGE_BITS];
                end
                SEL_LOCK: lock_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_addr))
            SEL_CTRL: rd_data[4:0] = {shadow.clamp, shadow.mag2x, shadow.mode, shadow.enable};
            SEL_POS: begin
                rd_data[COORD_W-1:0]      = shadow.pos_x;
                rd_data[Y_LSB +: COORD_W] = shadow.pos_y;
            end
            SEL_HOT: begin
                rd_data[HOT_W-1:0]         = shadow.hot_x;
                rd_data[HOTY_LSB +: HOT_W] = shadow.hot_y;
            end
            SEL_SIZE: begin
                rd_data[SIZE_W-1:0]      = shadow.w_m1;
                rd_data[H_LSB +: SIZE_W] = shadow.h_m1;
            end
            SEL_COL1: rd_data[COLOR_W-1:0] = shadow.col1;
            SEL_COL2: rd_data[COLOR_W-1:0] = shadow.col2;
            SEL_AHI:  rd_data[HI_W-1:0]    = hi_stage;
            SEL_ALO:  rd_data = {shadow.addr_lo, {PAGE_BITS{1'b0}}};
            SEL_LOCK: rd_data[1:0] = {pending, lock_q};
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cur_commit_fsm.sv
`timescale 1ns/1ps
module cur_commit_fsm
    import cur_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_q,
    input  logic dirty_wr,
    input  logic frame_strobe,
    output logic commit,
    output logic pending
);
    commit_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        pending = (state_q != CS_CLEAN);
        unique case (state_q)
            CS_CLEAN: begin
                if (dirty_wr) state_d = lock_q ? CS_HELD : CS_WAIT;
            end
            CS_HELD, CS_WAIT: begin
                if (!lock_q && frame_strobe) begin
                    commit  = 1'b1;
                    state_d = dirty_wr ? CS_WAIT : CS_CLEAN;
                end else begin
                    state_d = lock_q ? CS_HELD : CS_WAIT;
                end
            end
            default: state_d = CS_CLEAN;
        endcase
    end
endmodule

// File: rtl/cur_active_set.sv
`timescale 1ns/1ps
module cur_active_set
    import cur_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  cursor_cfg_t        shadow,
    output cursor_cfg_t        act_q,
    output logic [COLOR_W-1:0] col1_eff,
    output logic [COLOR_W-1:0] col2_eff
);
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= '0;
        else if (commit) act_q <= shadow;
    end

    always_comb begin
        if (act_q.mode == MODE_MONO) begin
            col1_eff = '0;
            col2_eff = '1;
        end else begin
            col1_eff = act_q.col1;
            col2_eff = act_q.col2;
        end
    end
endmodule

// File: rtl/cursor_regbank.sv
`timescale 1ns/1ps
module cursor_regbank
    import cur_regs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               frame_strobe,
    output logic               cur_enable,
    output logic [1:0]         cur_mode,
    output logic               cur_mag2x,
    output logic               cur_clamp,
    output logic [COORD_W-1:0] cur_pos_x,
    output logic [COORD_W-1:0] cur_pos_y,
    output logic [HOT_W-1:0]   cur_hot_x,
    output logic [HOT_W-1:0]   cur_hot_y,
    output logic [SIZE_W-1:0]  cur_width_m1,
    output logic [SIZE_W-1:0]  cur_height_m1,
    output logic [COLOR_W-1:0] cur_color1,
    output logic [COLOR_W-1:0] cur_color2,
    output logic [ADDR_W-1:0]  cur_base_addr
);
    cursor_cfg_t shadow, act_q;
    logic        lock_q, dirty_wr, commit, pending;

    cur_shadow_file u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .pending(pending),
        .rd_data(rd_data), .shadow(shadow), .lock_q(lock_q), .dirty_wr(dirty_wr)
    );

    cur_commit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lock_q(lock_q), .dirty_wr(dirty_wr),
        .frame_strobe(frame_strobe), .commit(commit), .pending(pending)
    );

    cur_active_set u_act (
        .clk(clk), .rst_n(rst_n), .commit(commit), .shadow(shadow),
        .act_q(act_q), .col1_eff(cur_color1), .col2_eff(cur_color2)
    );

    assign cur_enable    = act_q.enable;
    assign cur_mode      = act_q.mode;
    assign cur_mag2x     = act_q.mag2x;
    assign cur_clamp     = act_q.clamp;
    assign cur_pos_x     = act_q.pos_x;
    assign cur_pos_y     = act_q.pos_y;
    assign cur_hot_x     = act_q.hot_x;
    assign cur_hot_y     = act_q.hot_y;
    assign cur_width_m1  = act_q.w_m1;
    assign cur_height_m1 = act_q.h_m1;
    assign cur_base_addr = {act_q.addr_hi, act_q.addr_lo, {PAGE_BITS{1'b0}}};
endmodule

// File: rtl/cursor_regbank_chk.sv
`timescale 1ns/1ps
module cursor_regbank_chk
    import cur_regs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_addr,
    input logic             frame_strobe,
    input logic             lock_q,
    input logic             pending,
    input cursor_cfg_t      act_q
);
    assert_lock_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(act_q));

    assert_strobe_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(act_q));

    assert_pending_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == SEL_CTRL) |=> pending);

    assert_commit_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && !lock_q && !wr_en) |=> !pending);
endmodule

bind cursor_regbank cursor_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .frame_strobe(frame_strobe), .lock_q(lock_q), .pending(pending), .act_q(act_q)
);

// File: tb/sim_cursor_regbank.sv
`timescale 1ns/1ps
module sim_cursor_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        frame_strobe = 1'b0;
    logic        cur_enable, cur_mag2x, cur_clamp;
    logic [1:0]  cur_mode;
    logic [12:0] cur_pos_x, cur_pos_y;
    logic [5:0]  cur_hot_x, cur_hot_y;
    logic [7:0]  cur_width_m1, cur_height_m1;
    logic [23:0] cur_color1, cur_color2;
    logic [39:0] cur_base_addr;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cursor_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .frame_strobe(frame_strobe), .cur_enable(cur_enable), .cur_mode(cur_mode),
        .cur_mag2x(cur_mag2x), .cur_clamp(cur_clamp), .cur_pos_x(cur_pos_x),
        .cur_pos_y(cur_pos_y), .cur_hot_x(cur_hot_x), .cur_hot_y(cur_hot_y),
        .cur_width_m1(cur_width_m1), .cur_height_m1(cur_height_m1),
        .cur_color1(cur_color1), .cur_color2(cur_color2), .cur_base_addr(cur_base_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_strobe = 1'b1;
        @(negedge clk);
        frame_strobe = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd8, d);
        check("R1 status", 64'(d), 64'h0);
        check("R1 enable", 64'(cur_enable), 64'h0);
        check("R1 address", 64'(cur_base_addr), 64'h0);
        check("R1/R6 mono colour1", 64'(cur_color1), 64'h0);
        check("R1/R6 mono colour2", 64'(cur_color2), 64'hFFFFFF);
    endtask

    task automatic t_position();
        logic [31:0] d;
        wr(4'd1, (32'd200 << 16) | 32'd100);
        rd(4'd1, d);
        check("R5 position readback", 64'(d), 64'h00C80064);
        rd(4'd8, d);
        check("R4 pending set", 64'(d[1]), 64'h1);
        check("R3 no commit without strobe", 64'(cur_pos_x), 64'h0);
        strobe();
        check("R10 pos x", 64'(cur_pos_x), 64'd100);
        check("R10 pos y", 64'(cur_pos_y), 64'd200);
        rd(4'd8, d);
        check("R4 pending cleared", 64'(d[1]), 64'h0);
    endtask

    task automatic t_modes();
        wr(4'd4, 32'h112233);
        wr(4'd5, 32'h445566);
        wr(4'd0, 32'h0000000D);
        strobe();
        check("R10 enable", 64'(cur_enable), 64'h1);
        check("R6 mode premul", 64'(cur_mode), 64'h2);
        check("R10 mag", 64'(cur_mag2x), 64'h1);
        check("R10 clamp", 64'(cur_clamp), 64'h0);
        check("R6 colour1 pass", 64'(cur_color1), 64'h112233);
        check("R6 colour2 pass", 64'(cur_color2), 64'h445566);
        wr(4'd0, 32'h00000011);
        strobe();
        check("R6 mode mono", 64'(cur_mode), 64'h0);
        check("R6 mono forces black", 64'(cur_color1), 64'h0);
        check("R6 mono forces white", 64'(cur_color2), 64'hFFFFFF);
        check("R10 clamp set", 64'(cur_clamp), 64'h1);
    endtask

    task automatic t_size();
        wr(4'd3, 32'h00003F00);
        strobe();
        check("R7 width m1", 64'(cur_width_m1), 64'h0);
        check("R7 height m1", 64'(cur_height_m1), 64'd63);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(4'd8, 32'h1);
        wr(4'd2, 32'h00000A05);
        strobe();
        check("R2 hot x held", 64'(cur_hot_x), 64'h0);
        check("R2 hot y held", 64'(cur_hot_y), 64'h0);
        rd(4'd8, d);
        check("R4 pending while locked", 64'(d), 64'h3);
        wr(4'd8, 32'h0);
        repeat (3) @(negedge clk);
        check("R3 release waits for strobe", 64'(cur_hot_x), 64'h0);
        strobe();
        check("R3 hot x after strobe", 64'(cur_hot_x), 64'h5);
        check("R10 hot y after strobe", 64'(cur_hot_y), 64'hA);
    endtask

    task automatic t_address();
        logic [31:0] d;
        wr(4'd6, 32'h5A);
        strobe();
        check("R8 high alone no effect", 64'(cur_base_addr), 64'h0);
        rd(4'd6, d);
        check("R8 staged high readback", 64'(d), 64'h5A);
        wr(4'd7, 32'h12345FFF);
        rd(4'd7, d);
        check("R9 low bits read zero", 64'(d), 64'h12345000);
        check("R3 address before strobe", 64'(cur_base_addr), 64'h0);
        strobe();
        check("R8/R9 full address", 64'(cur_base_addr), 64'h5A12345000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_position();
        t_modes();
        t_size();
        t_lock();
        t_address();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule